// File: doc/BRIEF.md
# Oversampling Serial Receiver with Status Flags

This block receives asynchronous serial characters on a single line. It samples the line at sixteen times the bit rate and decides each bit by a majority vote over three samples taken near the middle of the bit. A character consists of a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. Each complete character is moved into a holding data register. A five-flag status register reports whether that register is full, whether the line has gone idle, whether a character was lost, whether the samples disagreed, and whether the stop bit was missing.

The sample-rate pulse comes from an external baud divider. A host reads the status and the data through a one-cycle read strobe with a select bit. All flags clear through one fixed sequence. A status read arms the clear for the flags that it saw set. A data read that follows then clears exactly those flags. A wake-hold input keeps the idle flag from setting while the host waits for a later event.

Top module: `serial_rx_status`

## Requirements
- R1: In 8-bit mode (`nine_bit_mode`=0), a valid character is presented on `rd_data[7:0]` with `rd_data[8]`=0 when `rd_sel`=1. Each bit value is the majority of three samples taken near the middle of the bit.
- R2: In 9-bit mode (`nine_bit_mode`=1), the nine data bits are returned on `rd_data[8:0]`.
- R3: With `rd_sel`=0, `rd_data` shows status: bit 0 full, bit 1 idle, bit 2 overrun, bit 3 noise, bit 4 framing, and bits 8:5 are zero. The full flag sets when a character enters the data register. A status read (`rd_en`=1, `rd_sel`=0) arms a clear of every flag it sees set, and the next data read (`rd_en`=1, `rd_sel`=1) clears those flags.
- R4: A data read that does not follow an armed status read returns the data and leaves every flag unchanged.
- R5: When a character completes while the data register is full or the overrun flag is set, the overrun flag sets and the held byte is kept. The clear sequence then returns the held byte, and reception resumes afterwards.
- R6: The noise flag sets together with the full flag when the three samples of the start bit, of any data bit or of the stop bit disagree. It does not set for a character lost to overrun.
- R7: The framing flag sets together with the full flag when the stop bit is decided as 0.
- R8: The idle flag sets once the line has been high for 160 consecutive sample ticks in 8-bit mode or 176 in 9-bit mode.
- R9: After the idle flag sets, it cannot set again until a new character has entered the data register.
- R10: The idle flag does not set while `wake_hold` is 1.
- R11: A low pulse whose middle samples vote high is a false start. The receiver goes back to hunting and no flag or data changes.
- R12: After reset, every status flag is 0 and the data register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Oversampling tick, 16 per bit |
| rx_line | input | 1 | Asynchronous serial receive line |
| nine_bit_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_hold | input | 1 | Suppresses idle-flag setting while 1 |
| rd_en | input | 1 | One-cycle read strobe |
| rd_sel | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | 9 | Selected register contents |

## Verification
The assertions assume several things about the inputs. Reads are single-cycle strobes. The mode input changes only while the line is idle between characters. The receive line is held for whole bit periods, apart from a deliberate one-tick glitch. Under those conditions, a data register that changes, a flag that falls, or a noise or framing flag that rises each point to one legal cause. The bench keeps the sample tick high on every clock. It drives each bit for exactly sixteen ticks and injects noise only as a single inverted tick on the middle sample. It switches the mode and the wake-hold input only between frames, and it issues reads only as one-cycle strobes in the status-then-data order or as a lone data read.

// File: rtl/rxf_pkg.sv
// Package: shared types for the oversampling serial receiver.
// Assumes: status layout is fixed; the bit order is visible at rd_data.
package rxf_pkg;

    // Receiver framing state.
    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Status flags; packed so that full is bit 0 and framing is bit 4.
    typedef struct packed {
        logic frame;
        logic noise;
        logic ovr;
        logic idle;
        logic full;
    } rx_stat_t;

    localparam int STAT_W = 5;
    localparam int DATA_W = 9;

endpackage

// File: rtl/rxf_frame_rx.sv
// Module: rxf_frame_rx
// Synchronises the receive line, hunts for a start edge and takes three
// mid-bit samples per bit. Each bit is decided by majority vote, and each
// finished character is reported as a one-cycle pulse that carries the
// data, the noise and the framing results.
// Assumes: tick pulses OSR times per bit; nine_bit is stable during a frame.
module rxf_frame_rx
    import rxf_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_raw,
    input  logic              nine_bit,
    output logic              rx_sync,
    output logic              chr_valid,
    output logic [DATA_W-1:0] chr_data,
    output logic              chr_noise,
    output logic              chr_frame
);

    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] MID_A    = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] MID_B    = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] MID_C    = CNT_W'(OSR / 2 + 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [3:0]        bit_idx_q;
    logic              prev_q;
    logic              s0_q;
    logic              s1_q;
    logic              noise_q;
    logic [DATA_W-1:0] shift_q;
    logic              vote;
    logic              disagree;
    logic [3:0]        last_idx;

    // Metastability synchroniser; the stage count picks the structure.
    generate
        if (SYNC_STAGES > 1) begin : g_sync_chain
            logic [SYNC_STAGES-1:0] sync_q;
            // Shift the raw line through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_raw};
            end
            assign rx_sync = sync_q[SYNC_STAGES-1];
        end else begin : g_sync_single
            logic sync_q;
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= rx_raw;
            end
            assign rx_sync = sync_q;
        end
    endgenerate

    // Majority vote of the two stored samples and the current one.
    always_comb begin
        vote     = (s0_q & s1_q) | (s0_q & rx_sync) | (s1_q & rx_sync);
        disagree = !((s0_q == s1_q) && (s1_q == rx_sync));
        last_idx = nine_bit ? 4'd8 : 4'd7;
    end

    // Framing state machine: start qualification, bit assembly, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_HUNT;
            cnt_q     <= '0;
            bit_idx_q <= '0;
            prev_q    <= 1'b1;
            s0_q      <= 1'b1;
            s1_q      <= 1'b1;
            noise_q   <= 1'b0;
            shift_q   <= '0;
            chr_valid <= 1'b0;
            chr_data  <= '0;
            chr_noise <= 1'b0;
            chr_frame <= 1'b0;
        end else begin
            chr_valid <= 1'b0;
            if (tick) begin
                prev_q <= rx_sync;
                if (state_q == RX_HUNT) begin
                    if (prev_q && !rx_sync) begin
                        state_q <= RX_START;
                        cnt_q   <= CNT_W'(1);
                        noise_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                    if (cnt_q == MID_A) s0_q <= rx_sync;
                    if (cnt_q == MID_B) s1_q <= rx_sync;
                    if (cnt_q == MID_C) begin
                        case (state_q)
                            RX_START: begin
                                if (vote) begin
                                    state_q <= RX_HUNT;
                                end else begin
                                    noise_q   <= disagree;
                                    state_q   <= RX_DATA;
                                    bit_idx_q <= '0;
                                end
                            end
                            RX_DATA: begin
                                shift_q <= {vote, shift_q[DATA_W-1:1]};
                                noise_q <= noise_q | disagree;
                                if (bit_idx_q == last_idx) begin
                                    state_q <= RX_STOP;
                                end else begin
                                    bit_idx_q <= bit_idx_q + 4'd1;
                                end
                            end
                            RX_STOP: begin
                                chr_valid <= 1'b1;
                                chr_data  <= nine_bit ? shift_q
                                                      : {1'b0, shift_q[DATA_W-1:1]};
                                chr_noise <= noise_q | disagree;
                                chr_frame <= !vote;
                                state_q   <= RX_HUNT;
                            end
                            default: state_q <= RX_HUNT;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rxf_idle_det.sv
// Module: rxf_idle_det
// Counts consecutive high sample ticks and raises a one-cycle idle event
// when a full frame length of ones has been seen. The event is armed only
// by a character transfer, and it is withheld while wake_hold is set.
// Assumes: rx_sync is already synchronous; tick as in the framing block.
module rxf_idle_det #(
    parameter int OSR      = 16,
    parameter int FRAME8   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_sync,
    input  logic nine_bit,
    input  logic wake_hold,
    input  logic rearm,
    output logic idle_set
);

    localparam int LIM8_I = OSR * FRAME8;
    localparam int LIM9_I = OSR * (FRAME8 + 1);
    localparam int CW     = $clog2(LIM9_I + 1);
    localparam logic [CW-1:0] LIM8 = CW'(LIM8_I);
    localparam logic [CW-1:0] LIM9 = CW'(LIM9_I);

    logic [CW-1:0] ones_q;
    logic [CW-1:0] limit;
    logic          armed_q;
    logic          hit;

    // Frame-length threshold and the tick on which it is reached.
    always_comb begin
        limit    = nine_bit ? LIM9 : LIM8;
        hit      = tick && rx_sync && (ones_q == limit - 1'b1);
        idle_set = hit && armed_q && !wake_hold;
    end

    // Saturating count of consecutive high ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (tick) begin
            if (!rx_sync)            ones_q <= '0;
            else if (ones_q != LIM9) ones_q <= ones_q + 1'b1;
        end
    end

    // Arming: set by a character transfer, spent by an idle event.
    always_ff @(posedge clk) begin
        if (!rst_n)        armed_q <= 1'b0;
        else if (rearm)    armed_q <= 1'b1;
        else if (idle_set) armed_q <= 1'b0;
    end

endmodule

// File: rtl/rxf_status_regs.sv
// Module: rxf_status_regs
// Holds the received data register and the five status flags, and runs
// the status-read-then-data-read clear sequence. A character is accepted
// only while neither the full flag nor the overrun flag is set.
// Assumes: rd_en is a single-cycle strobe.
module rxf_status_regs
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_noise,
    input  logic              chr_frame,
    input  logic              idle_set,
    input  logic              rd_en,
    input  logic              rd_sel,
    output rx_stat_t          stat_q,
    output logic [DATA_W-1:0] data_q,
    output logic              xfer
);

    rx_stat_t arm_q;
    rx_stat_t clr;
    logic     ovr_set;
    logic     stat_rd;
    logic     data_rd;

    // Transfer, overrun and clear decisions for this cycle.
    always_comb begin
        stat_rd = rd_en && !rd_sel;
        data_rd = rd_en && rd_sel;
        xfer    = chr_valid && !stat_q.full && !stat_q.ovr;
        ovr_set = chr_valid && (stat_q.full || stat_q.ovr);
        clr     = data_rd ? arm_q : '0;
    end

    // Clear arming: captured by a status read, consumed by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       arm_q <= '0;
        else if (stat_rd) arm_q <= stat_q;
        else if (data_rd) arm_q <= '0;
    end

    // Flag update: armed clear, then new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q.full  <= (stat_q.full  & ~clr.full)  | xfer;
            stat_q.idle  <= (stat_q.idle  & ~clr.idle)  | idle_set;
            stat_q.ovr   <= (stat_q.ovr   & ~clr.ovr)   | ovr_set;
            stat_q.noise <= (stat_q.noise & ~clr.noise) | (xfer & chr_noise);
            stat_q.frame <= (stat_q.frame & ~clr.frame) | (xfer & chr_frame);
        end
    end

    // Data register load on accepted characters only.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (xfer) data_q <= chr_data;
    end

endmodule

// File: rtl/serial_rx_status.sv
// Module: serial_rx_status (top)
// Oversampling serial receiver with a data register, five status flags and
// a two-register read port. It ties together framing, idle detection and
// the flag registers.
// Assumes: sample_en comes from an external baud divider at OSR per bit.
module serial_rx_status
    import rxf_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FRAME8      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rx_line,
    input  logic              nine_bit_mode,
    input  logic              wake_hold,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic              rx_sync;
    logic              chr_valid;
    logic [DATA_W-1:0] chr_data;
    logic              chr_noise;
    logic              chr_frame;
    logic              idle_set;
    logic              xfer;
    rx_stat_t          stat_q;
    logic [STAT_W-1:0] stat_bits;
    logic [DATA_W-1:0] data_q;

    rxf_frame_rx #(
        .OSR         (OSR),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_en),
        .rx_raw    (rx_line),
        .nine_bit  (nine_bit_mode),
        .rx_sync   (rx_sync),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .chr_noise (chr_noise),
        .chr_frame (chr_frame)
    );

    rxf_idle_det #(
        .OSR    (OSR),
        .FRAME8 (FRAME8)
    ) i_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sample_en),
        .rx_sync   (rx_sync),
        .nine_bit  (nine_bit_mode),
        .wake_hold (wake_hold),
        .rearm     (xfer),
        .idle_set  (idle_set)
    );

    rxf_status_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .chr_noise (chr_noise),
        .chr_frame (chr_frame),
        .idle_set  (idle_set),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .stat_q    (stat_q),
        .data_q    (data_q),
        .xfer      (xfer)
    );

    // Read multiplexer: status padded with zeros, or the data register.
    always_comb begin
        stat_bits = stat_q;
        rd_data   = rd_sel ? data_q : {{(DATA_W-STAT_W){1'b0}}, stat_bits};
    end

endmodule

// File: rtl/rxf_checker.sv
// Module: rxf_checker
// Temporal checks on the flag register and the data register of the
// receiver, attached to the top module by bind.
// Assumes: synchronous active-low reset; flag bits as listed in R3.
module rxf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_hold,
    input logic       rd_en,
    input logic       rd_sel,
    input logic [4:0] stat,
    input logic [8:0] data_q
);

    assert_full_falls_on_data_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[0]) |-> $past(rd_en && rd_sel));

    assert_data_moves_with_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> $rose(stat[0]));

    assert_held_byte_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat[2] |=> $stable(data_q));

    assert_noise_with_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[3]) |-> $rose(stat[0]));

    assert_frame_with_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[4]) |-> $rose(stat[0]));

    assert_no_idle_under_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> !$past(wake_hold));

endmodule

bind serial_rx_status rxf_checker i_rxf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_hold (wake_hold),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .stat      (stat_bits),
    .data_q    (data_q)
);

// File: tb/test_serial_rx_status.sv
// Bench for serial_rx_status. A driver queues expected characters as it
// sends them, and a monitor pops the queue and checks each one as the
// full flag appears. The directed phases that follow cover idle, overrun,
// the lone data read and the false start.
module test_serial_rx_status;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sample_en;
    logic       rx_line;
    logic       nine_bit_mode;
    logic       wake_hold;
    logic       rd_en;
    logic       rd_sel;
    logic [8:0] rd_data;

    int  n_chk  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    int  stop_cyc = 0;
    bit  mon_on = 1'b0;

    typedef struct {
        logic [8:0] d;
        bit         n;
        bit         f;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_rx_status i_serial_rx_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_en     (sample_en),
        .rx_line       (rx_line),
        .nine_bit_mode (nine_bit_mode),
        .wake_hold     (wake_hold),
        .rd_en         (rd_en),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Send one frame; glitch_pos inverts the middle sample of that position
    // (0 start, 1..n data, n+1 stop).
    task automatic send(input logic [8:0] d, input bit nine, input bit stop_v,
                        input int glitch_pos, input bit push);
        int   nb;
        exp_t e;
        nb = nine ? 9 : 8;
        if (push) begin
            e.d = nine ? d : {1'b0, d[7:0]};
            e.n = (glitch_pos >= 0);
            e.f = !stop_v;
            sb_q.push_back(e);
        end
        for (int p = 0; p < nb + 2; p++) begin
            logic v;
            v = (p == 0) ? 1'b0 : (p == nb + 1) ? stop_v : d[p-1];
            if (p == nb + 1) stop_cyc = cyc;
            for (int t = 0; t < 16; t++) begin
                @(negedge clk);
                rx_line = (p == glitch_pos && t == 8) ? ~v : v;
            end
        end
        @(negedge clk);
        rx_line = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic clear_seq(output logic [8:0] dout);
        @(negedge clk); rd_en = 1'b1; rd_sel = 1'b0;
        @(negedge clk); rd_sel = 1'b1; #1 dout = rd_data;
        @(negedge clk); rd_en = 1'b0; rd_sel = 1'b0; #1;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
        #1;
    endtask

    // Monitor: pops the scoreboard when the full flag shows up.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on && !rd_en && !rd_sel && rd_data[0]) begin
                exp_t       e;
                logic [8:0] got;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R3 unexpected character", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(rd_data[3] == e.n, "R6 noise flag", rd_data[3], e.n);
                    check(rd_data[4] == e.f, "R7 framing flag", rd_data[4], e.f);
                    clear_seq(got);
                    check(got == e.d, "R1 or R2 received data", got, e.d);
                    check(rd_data[4:0] == 5'd0 || rd_data[4:0] == 5'b00010,
                          "R3 flags cleared by sequence", rd_data[4:0], 0);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] got;
        rst_n = 1'b0; sample_en = 1'b1; rx_line = 1'b1; nine_bit_mode = 1'b0;
        wake_hold = 1'b0; rd_en = 1'b0; rd_sel = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        // R12 reset state
        check(rd_data == 9'd0, "R12 status after reset", rd_data, 0);
        rd_sel = 1'b1; #1;
        check(rd_data == 9'd0, "R12 data after reset", rd_data, 0);
        rd_sel = 1'b0;

        // Scoreboarded characters: R1, R2, R6, R7
        mon_on = 1'b1;
        send(9'h0A5, 1'b0, 1'b1, -1, 1'b1);
        send(9'h03C, 1'b0, 1'b1, 4, 1'b1);
        send(9'h000, 1'b0, 1'b0, -1, 1'b1);
        send(9'h0FF, 1'b0, 1'b1, 0, 1'b1);
        nine_bit_mode = 1'b1;
        send(9'h1A5, 1'b1, 1'b1, -1, 1'b1);
        send(9'h0F0, 1'b1, 1'b1, 10, 1'b1);
        nine_bit_mode = 1'b0;
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R1 all characters delivered", sb_q.size(), 0);
        mon_on = 1'b0;

        // R8 idle in 8-bit mode, then R9 re-arm
        repeat (200) @(negedge clk);
        clear_seq(got);
        send(9'h03C, 1'b0, 1'b1, -1, 1'b0);
        wait_until(stop_cyc + 150);
        check(rd_data[1] == 1'b0, "R8 idle not yet at 150 ticks", rd_data[1], 0);
        wait_until(stop_cyc + 172);
        check(rd_data[1] == 1'b1, "R8 idle after 160 ticks", rd_data[1], 1);
        clear_seq(got);
        check(got == 9'h03C, "R3 data via clear sequence", got, 9'h03C);
        check(rd_data[4:0] == 5'd0, "R3 status cleared", rd_data[4:0], 0);
        repeat (250) @(negedge clk); #1;
        check(rd_data[1] == 1'b0, "R9 idle stays clear without new character", rd_data[1], 0);

        // R10 wake hold
        wake_hold = 1'b1;
        send(9'h03C, 1'b0, 1'b1, -1, 1'b0);
        wait_until(stop_cyc + 200);
        check(rd_data[1] == 1'b0, "R10 idle held off", rd_data[1], 0);
        check(rd_data[0] == 1'b1, "R10 character still received", rd_data[0], 1);
        clear_seq(got);
        wake_hold = 1'b0;

        // R8 idle length in 9-bit mode, R2 data
        nine_bit_mode = 1'b1;
        send(9'h0A5, 1'b1, 1'b1, -1, 1'b0);
        wait_until(stop_cyc + 165);
        check(rd_data[1] == 1'b0, "R8 nine-bit idle not at 165 ticks", rd_data[1], 0);
        wait_until(stop_cyc + 185);
        check(rd_data[1] == 1'b1, "R8 nine-bit idle after 176 ticks", rd_data[1], 1);
        clear_seq(got);
        check(got == 9'h0A5, "R2 nine-bit data", got, 9'h0A5);
        nine_bit_mode = 1'b0;
        repeat (5) @(negedge clk);

        // R4 lone data read
        send(9'h05A, 1'b0, 1'b1, -1, 1'b0);
        @(negedge clk); rd_en = 1'b1; rd_sel = 1'b1; #1 got = rd_data;
        @(negedge clk); rd_en = 1'b0; rd_sel = 1'b0; #1;
        check(got == 9'h05A, "R4 lone data read value", got, 9'h05A);
        check(rd_data[0] == 1'b1, "R4 full unchanged by lone data read", rd_data[0], 1);
        clear_seq(got);
        check(rd_data[0] == 1'b0, "R4 full cleared by proper sequence", rd_data[0], 0);

        // R5 overrun, R6 noise suppressed on lost character
        send(9'h011, 1'b0, 1'b1, -1, 1'b0);
        send(9'h022, 1'b0, 1'b1, 3, 1'b0);
        #1;
        check(rd_data[0] == 1'b1, "R5 full during overrun", rd_data[0], 1);
        check(rd_data[2] == 1'b1, "R5 overrun flag", rd_data[2], 1);
        check(rd_data[3] == 1'b0, "R6 no noise for lost character", rd_data[3], 0);
        clear_seq(got);
        check(got == 9'h011, "R5 held byte returned", got, 9'h011);
        check(rd_data[4:0] == 5'd0, "R5 overrun cleared", rd_data[4:0], 0);
        send(9'h033, 1'b0, 1'b1, -1, 1'b0);
        clear_seq(got);
        check(got == 9'h033, "R5 reception resumes", got, 9'h033);

        // R11 false start
        for (int t = 0; t < 4; t++) begin @(negedge clk); rx_line = 1'b0; end
        @(negedge clk); rx_line = 1'b1;
        repeat (40) @(negedge clk); #1;
        check(rd_data[4:0] == 5'd0, "R11 no flag on false start", rd_data[4:0], 0);
        rd_sel = 1'b1; #1;
        check(rd_data == 9'h033, "R11 data unchanged by false start", rd_data, 9'h033);
        rd_sel = 1'b0;
        send(9'h044, 1'b0, 1'b1, -1, 1'b0);
        clear_seq(got);
        check(got == 9'h044, "R11 receiver recovers", got, 9'h044);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule